// File: doc/BRIEF.md
# Flow Hash to CPU Indirection Mapper

This block turns a 32-bit flow hash into the number of the CPU (or receive queue) that should handle the packet. It sits after the hash engine in a receive path. It takes the low configured bits of the hash and uses them to read an entry from a host-programmable steering table. It then keeps only the queue bits the hardware supports and adds a base CPU number. The chosen CPU and the untouched hash leave together one cycle later, ready to be written into the receive descriptor.

Packets that arrive without any hash-type flag set do not use the table. They go straight to the base CPU. The host can rewrite table entries while traffic is flowing, and a packet may briefly reach a stale CPU during such an update. The index width, base CPU and queue mask are treated as static and are changed only around a reset.

Top module: `hash_cpu_mapper`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is 0. Reset clears every table entry to 0.
- R2: Each cycle with `in_valid` high yields exactly one cycle with `out_valid` high on the next clock. A cycle without `in_valid` yields `out_valid` low on the next clock. One lookup is accepted per cycle.
- R3: The table index is `in_hash[n-1:0]`, where n is `cfg_hash_bits` (legal values 1 to 7). A value of 0 is treated as 1.
- R4: The table entry is bitwise ANDed with `cfg_queue_mask` before the base is added, so the result always lies within `cfg_base_cpu` plus the mask window.
- R5: `out_cpu` = (`cfg_base_cpu` + masked entry) modulo 256. The configuration used is the one present in the lookup cycle.
- R6: `out_hash` equals the `in_hash` of the lookup, all 32 bits unchanged.
- R7: When `in_type` is 4'b0000 (no hash was computed), `out_cpu` equals `cfg_base_cpu` whatever the table holds.
- R8: A write of `tbl_wr_data` to entry `tbl_wr_addr` is seen by every lookup made in a later cycle. Writes may be made at any time during traffic.
- R9: A lookup of an entry in the same cycle that entry is written returns the entry's value from before the write.
- R10: Hash bits at or above the configured index width do not affect `out_cpu`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A hash is present this cycle |
| in_hash | input | 32 | Flow hash |
| in_type | input | 4 | Hash-type flags; all zero means the packet carries no hash |
| tbl_wr_en | input | 1 | Write one steering-table entry |
| tbl_wr_addr | input | 7 | Entry to write |
| tbl_wr_data | input | 8 | New entry value |
| cfg_hash_bits | input | 3 | Number of low hash bits used as index (1 to 7) |
| cfg_base_cpu | input | 8 | Offset added to the masked entry |
| cfg_queue_mask | input | 8 | Mask of the queue bits the hardware supports |
| out_valid | output | 1 | Result present |
| out_cpu | output | 8 | Selected CPU number |
| out_hash | output | 32 | Hash passed through |

## Verification
The assertions check the following relations on every cycle:
- the one-cycle valid timing;
- hash pass-through;
- bypass to the base CPU for packets without a hash;
- that every hashed result lands inside the base-plus-mask window;
- that each table write is stored.

Only the bench's scenarios can show which entry a given hash selects, because that depends on table contents the bench itself wrote. The same holds for:
- hash bits above the index width being ignored;
- a width of 0 being treated as 1;
- wrap-around of the base sum;
- the old value being returned when a write and a read hit the same entry in one cycle.

// File: rtl/hcm_pkg.sv
package hcm_pkg;
    localparam int HASH_W   = 32;
    localparam int IDX_W    = 7;
    localparam int CPU_W    = 8;
    localparam int TYPE_W   = 4;
    localparam int HB_W     = $clog2(IDX_W + 1);

    // Effective index width: 0 is promoted to 1, anything above IDX_W clamps.
    function automatic int eff_bits(input logic [HB_W-1:0] bits);
        int b;
        b = int'(bits);
        if (b < 1)     b = 1;
        if (b > IDX_W) b = IDX_W;
        return b;
    endfunction

    typedef struct packed {
        logic              vld;
        logic              hashed;
        logic [HASH_W-1:0] hash;
        logic [CPU_W-1:0]  base;
        logic [CPU_W-1:0]  qmask;
    } stage_t;
endpackage

// File: rtl/hcm_index_sel.sv
module hcm_index_sel
    import hcm_pkg::*;
#(
    parameter int HW = HASH_W,
    parameter int IW = IDX_W,
    parameter int BW = HB_W
) (
    input  logic [HW-1:0] hash,
    input  logic [BW-1:0] hash_bits,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] keep;

    always_comb begin
        keep = '0;
        for (int i = 0; i < IW; i++) begin
            keep[i] = (i < eff_bits(hash_bits));
        end
        idx = hash[IW-1:0] & keep;
    end
endmodule

// File: rtl/hcm_table.sv
module hcm_table #(
    parameter int IW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] mem [DEPTH];

    // Read samples the pre-write contents in the same edge (old value wins).
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (rd_en) rd_data <= mem[rd_addr];
            if (wr_en) mem[wr_addr] <= wr_data;
        end
    end

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R8
endmodule

// File: rtl/hcm_compose.sv
module hcm_compose #(
    parameter int CW = 8
) (
    input  logic          hashed,
    input  logic [CW-1:0] entry,
    input  logic [CW-1:0] qmask,
    input  logic [CW-1:0] base,
    output logic [CW-1:0] cpu
);
    always_comb begin
        if (hashed) cpu = base + (entry & qmask);
        else        cpu = base;
    end
endmodule

// File: rtl/hash_cpu_mapper.sv
module hash_cpu_mapper
    import hcm_pkg::*;
#(
    parameter int HW = HASH_W,
    parameter int IW = IDX_W,
    parameter int CW = CPU_W,
    parameter int TW = TYPE_W,
    parameter int BW = HB_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [HW-1:0] in_hash,
    input  logic [TW-1:0] in_type,
    input  logic          tbl_wr_en,
    input  logic [IW-1:0] tbl_wr_addr,
    input  logic [CW-1:0] tbl_wr_data,
    input  logic [BW-1:0] cfg_hash_bits,
    input  logic [CW-1:0] cfg_base_cpu,
    input  logic [CW-1:0] cfg_queue_mask,
    output logic          out_valid,
    output logic [CW-1:0] out_cpu,
    output logic [HW-1:0] out_hash
);
    logic [IW-1:0] idx;
    logic [CW-1:0] entry;
    logic          in_hashed;
    stage_t        st_q;

    assign in_hashed = |in_type;

    hcm_index_sel #(.HW(HW), .IW(IW), .BW(BW)) u_idx (
        .hash      (in_hash),
        .hash_bits (cfg_hash_bits),
        .idx       (idx)
    );

    hcm_table #(.IW(IW), .DW(CW)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_en   (in_valid && in_hashed),
        .rd_addr (idx),
        .rd_data (entry)
    );

    // Side-band stage travels alongside the registered table read.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.vld    <= in_valid;
            st_q.hashed <= in_hashed;
            st_q.hash   <= in_hash;
            st_q.base   <= cfg_base_cpu;
            st_q.qmask  <= cfg_queue_mask;
        end
    end

    hcm_compose #(.CW(CW)) u_cmp (
        .hashed (st_q.hashed),
        .entry  (entry),
        .qmask  (st_q.qmask),
        .base   (st_q.base),
        .cpu    (out_cpu)
    );

    assign out_valid = st_q.vld;
    assign out_hash  = st_q.hash;

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_HASH_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_hash == $past(in_hash)); // R6
    AST_NOHASH_BASE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_type == '0) |=> out_cpu == $past(cfg_base_cpu)); // R7
    AST_CPU_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_type != '0) |=>
            ((out_cpu - $past(cfg_base_cpu)) & ~$past(cfg_queue_mask)) == '0); // R4
endmodule

// File: tb/hash_cpu_mapper_tb.sv
module hash_cpu_mapper_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_hash;
    logic [3:0]  in_type;
    logic        tbl_wr_en;
    logic [6:0]  tbl_wr_addr;
    logic [7:0]  tbl_wr_data;
    logic [2:0]  cfg_hash_bits;
    logic [7:0]  cfg_base_cpu;
    logic [7:0]  cfg_queue_mask;
    logic        out_valid;
    logic [7:0]  out_cpu;
    logic [31:0] out_hash;

    int checks = 0;
    int errors = 0;
    int ref_tbl [128];
    logic [31:0] seed = 32'h1357_9bdf;

    always #5 clk = ~clk;

    hash_cpu_mapper u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_hash(in_hash), .in_type(in_type),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .cfg_hash_bits(cfg_hash_bits), .cfg_base_cpu(cfg_base_cpu),
        .cfg_queue_mask(cfg_queue_mask), .out_valid(out_valid), .out_cpu(out_cpu),
        .out_hash(out_hash)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model, wait an edge, compare at next negedge.
    task automatic step(input logic v, input logic [31:0] h, input logic [3:0] t,
                        input logic we, input logic [6:0] wa, input logic [7:0] wd,
                        input string tag);
        int nb, idx, ecpu;
        in_valid = v; in_hash = h; in_type = t;
        tbl_wr_en = we; tbl_wr_addr = wa; tbl_wr_data = wd;
        nb = int'(cfg_hash_bits);
        if (nb < 1) nb = 1;
        idx = int'(h) & ((1 << nb) - 1);
        if (t != 4'd0) ecpu = (int'(cfg_base_cpu) + (ref_tbl[idx] & int'(cfg_queue_mask))) % 256;
        else           ecpu = int'(cfg_base_cpu);
        if (we) ref_tbl[wa] = int'(wd);
        @(posedge clk);
        @(negedge clk);
        check(tag, "out_valid", longint'(out_valid), longint'(v));
        if (v) begin
            check(tag, "out_cpu", longint'(out_cpu), longint'(ecpu));
            check("R6", "out_hash", longint'(out_hash), longint'(h));
        end
    endtask

    task automatic lookup(input logic [31:0] h, input string tag);
        step(1'b1, h, 4'b0001, 1'b0, 7'd0, 8'd0, tag);
    endtask

    task automatic wr(input int a, input int d);
        step(1'b0, 32'd0, 4'd0, 1'b1, 7'(a), 8'(d), "R2");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) ref_tbl[i] = 0;
        rst = 1'b1; in_valid = 0; in_hash = 0; in_type = 0;
        tbl_wr_en = 0; tbl_wr_addr = 0; tbl_wr_data = 0;
        cfg_hash_bits = 3'd7; cfg_base_cpu = 8'd0; cfg_queue_mask = 8'hff;
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", longint'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "out_valid after reset", longint'(out_valid), 0);

        // R1: cleared table reads as zero
        lookup(32'h0000_0005, "R1");
        lookup(32'hffff_ff7f, "R1");

        // Fill table; idle cycles keep out_valid low (R2)
        for (int i = 0; i < 128; i++) wr(i, (i * 37 + 5) & 255);

        // R3 / R5: full 7-bit index, back-to-back lookups
        for (int i = 0; i < 16; i++) lookup(32'(i * 9 + 3), "R3");

        // R10: upper bits ignored with 3-bit index
        cfg_hash_bits = 3'd3;
        lookup(32'h0000_0006, "R10");
        lookup(32'hdead_bee6, "R10");
        lookup(32'h7fff_fffe, "R10");

        // R3: width 0 treated as 1
        cfg_hash_bits = 3'd0;
        lookup(32'h0000_0003, "R3");
        lookup(32'h0000_0002, "R3");

        // R4 / R5: four queues, base 4
        cfg_hash_bits = 3'd7; cfg_queue_mask = 8'h03; cfg_base_cpu = 8'd4;
        for (int i = 0; i < 8; i++) lookup(32'(i * 13), "R4");

        // R5: base wrap-around
        cfg_queue_mask = 8'hff; cfg_base_cpu = 8'd250;
        lookup(32'd20, "R5");
        lookup(32'd127, "R5");

        // R7: no hash flags -> base, table bypassed
        step(1'b1, 32'd20, 4'd0, 1'b0, 7'd0, 8'd0, "R7");
        step(1'b1, 32'd99, 4'd0, 1'b0, 7'd0, 8'd0, "R7");

        // R9 then R8: same-cycle write/read, then new value seen
        cfg_base_cpu = 8'd0;
        step(1'b1, 32'd40, 4'b0010, 1'b1, 7'd40, 8'h5a, "R9");
        lookup(32'd40, "R8");

        // Mixed traffic with live writes
        cfg_queue_mask = 8'h0f; cfg_base_cpu = 8'd16; cfg_hash_bits = 3'd6;
        for (int i = 0; i < 200; i++) begin
            logic [31:0] r1, r2;
            seed = next_rand(seed); r1 = seed;
            seed = next_rand(seed); r2 = seed;
            step(r1[0] | r1[1], r2, r1[7:4], r1[2], r1[14:8], r1[23:16], "R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule